// File: doc/BRIEF.md
# Head Positioning Step Controller

This block moves the read/write heads of up to four floppy drives. The command sequencer hands it one move at a time, either a seek with a target cylinder or a recalibrate. The block keeps the present cylinder of every drive. For each move it drives the direction line and emits step pulses at a programmed interval, with the timing taken from a millisecond tick input. A recalibrate steps toward the spindle edge until the selected drive reports track zero. If track zero never appears, the recalibrate gives up after a fixed number of steps.

When a move ends, the block builds a status byte 0 and raises an interrupt-pending flag. A sense-interrupt read takes the status byte and the present cylinder of the drive that just finished, and the same read clears the flag. The step interval comes from a 4-bit field taken from the specify parameters. While a drive is moving, its busy bit is set. Only one move runs at a time, and a new request is taken only when the block is idle.

Top module: `head_step_ctrl`

## Requirements
- R1: After reset the controller is idle: `reqReady` is 1, and `stepOut`, `driveBusy` and `intPending` are 0. `st0Out` reads 0x80 and `pcnOut` reads 0. The present cylinder of every drive is 0 and the rate field is 0.
- R2: A request is accepted only on a cycle where both `reqValid` and `reqReady` are 1. `reqReady` is 0 while a move is in progress, and a request made during a move is ignored: the running move ends with its own target, its own step count and its own status.
- R3: A seek drives `dirOut` to 1 when the target is above the present cylinder and to 0 when it is below. It emits exactly |target - present| step pulses, and the drive's present cylinder then equals the target. The status byte for a normal end is 0x20 | head<<2 | unit.
- R4: Each step pulse is high for exactly one tick period. Between two pulses of the same move, the rising edges are N+1 ticks apart, where N = 16 - rate and rate is the 4-bit field written with `specWe`. A rate of 15 gives N = 1, and a rate of 0 gives N = 16.
- R5: A seek whose target equals the present cylinder emits no pulse. It completes on the first clock after acceptance, without waiting for a tick, and its status is 0x20 | head<<2 | unit.
- R6: A recalibrate steps with `dirOut` = 0 until `trackZero[unit]` is 1 at a decision point. It then ends normally with status 0x20 | head<<2 | unit and sets that drive's present cylinder to 0.
- R7: If a recalibrate has issued 77 pulses and track zero is still 0, it ends with status 0x70 | head<<2 | unit: bits 7:6 = 01 (abnormal), bit 5 = seek end and bit 4 = equipment check. Exactly 77 pulses are issued and the drive's present cylinder is left unchanged.
- R8: `driveBusy[unit]` is 1 from the clock after acceptance until completion, and at most one busy bit is ever set. `stepOut` is high only while the busy bit of `stepUnit` is set.
- R9: `intPending` rises on the clock that clears the busy bit. A cycle with `senseRd` = 1 clears it. While it is set, `st0Out` and `pcnOut` hold the finished move's status and present cylinder; while it is clear, `st0Out` reads 0x80.
- R10: Each drive keeps its own present cylinder, and moves on one drive never change another drive's cylinder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msTick | input | 1 | One-cycle millisecond tick |
| specWe | input | 1 | Load the step-rate field |
| specRate | input | 4 | Step-rate field (interval = 16 - value ticks) |
| reqValid | input | 1 | Move request strobe |
| reqRecal | input | 1 | 1 = recalibrate, 0 = seek |
| reqUnit | input | 2 | Drive number of the request |
| reqHead | input | 1 | Head number reported in status |
| reqCyl | input | 8 | Seek target cylinder |
| reqReady | output | 1 | Idle, a request is accepted |
| trackZero | input | 4 | Track-zero sense per drive |
| senseRd | input | 1 | Sense-interrupt read, clears pending |
| stepOut | output | 1 | Step pulse |
| dirOut | output | 1 | 1 = toward higher cylinders |
| stepUnit | output | 2 | Drive the step pulses address |
| driveBusy | output | 4 | Per-drive moving flag |
| intPending | output | 1 | Move completed, not yet sensed |
| st0Out | output | 8 | Status byte 0 of last move, 0x80 when nothing pending |
| pcnOut | output | 8 | Present cylinder of the last finished drive |

## Verification
The assertions take for granted that `msTick` is a single-cycle pulse and that `senseRd` and `reqValid` are synchronous to `clk`. They also assume `trackZero` is already synchronized, so its value can change between decision points without glitching the state machine. The stimulus pulses `msTick` for one clock out of every five and raises `senseRd` only for one cycle after it sees `intPending`. It derives `trackZero` from a model of the head positions that follows the emitted pulses. One drive has its track-zero line held low, so the step-limit path is exercised.

// File: rtl/head_step_pkg.sv
package head_step_pkg;

  typedef enum logic [1:0] {
    S_IDLE,
    S_ARM,
    S_HIGH,
    S_LOW
  } stepState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;
    logic stepNow;
    logic endHigh;
    logic tickLow;
    logic finishOk;
    logic finishFail;
  } ctrlStrobe_t;

  // conditions from datapath to control
  typedef struct packed {
    logic isRecal;
    logic atTarget;
    logic trackZero;
    logic limitHit;
    logic gapDone;
  } dpFlags_t;

  localparam logic [7:0] ST0_IDLE = 8'h80;

endpackage

// File: rtl/head_step_fsm.sv
module head_step_fsm
  import head_step_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        msTick,
  input  logic        reqValid,
  input  dpFlags_t    flags,
  output logic        reqReady,
  output ctrlStrobe_t ctl
);

  stepState_t state, stateNext;
  logic moveDone, moveOk;

  // decision: a recalibrate ends on track zero or on the step limit
  always_comb begin
    if (flags.isRecal) begin
      moveDone = flags.trackZero | flags.limitHit;
      moveOk   = flags.trackZero;
    end else begin
      moveDone = flags.atTarget;
      moveOk   = flags.atTarget;
    end
  end

  always_comb begin
    stateNext = state;
    ctl       = '0;
    reqReady  = 1'b0;
    unique case (state)
      S_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          ctl.latchReq = 1'b1;
          stateNext    = S_ARM;
        end
      end
      S_ARM: begin
        if (moveDone) begin
          ctl.finishOk   = moveOk;
          ctl.finishFail = ~moveOk;
          stateNext      = S_IDLE;
        end else if (msTick) begin
          ctl.stepNow = 1'b1;
          stateNext   = S_HIGH;
        end
      end
      S_HIGH: begin
        if (msTick) begin
          ctl.endHigh = 1'b1;
          stateNext   = S_LOW;
        end
      end
      S_LOW: begin
        if (msTick) begin
          if (!flags.gapDone) begin
            ctl.tickLow = 1'b1;
          end else if (moveDone) begin
            ctl.finishOk   = moveOk;
            ctl.finishFail = ~moveOk;
            stateNext      = S_IDLE;
          end else begin
            ctl.stepNow = 1'b1;
            stateNext   = S_HIGH;
          end
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= stateNext;
  end

endmodule

// File: rtl/head_step_dp.sv
module head_step_dp
  import head_step_pkg::*;
#(
  parameter int NUM_DRIVES  = 4,
  parameter int CYL_W       = 8,
  parameter int RATE_W      = 4,
  parameter int RECAL_LIMIT = 77,
  localparam int UNIT_W     = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  ctrlStrobe_t           ctl,
  input  logic                  specWe,
  input  logic [RATE_W-1:0]     specRate,
  input  logic                  reqRecal,
  input  logic [UNIT_W-1:0]     reqUnit,
  input  logic                  reqHead,
  input  logic [CYL_W-1:0]      reqCyl,
  input  logic                  senseRd,
  input  logic [NUM_DRIVES-1:0] trackZero,
  output dpFlags_t              flags,
  output logic                  stepOut,
  output logic                  dirOut,
  output logic [UNIT_W-1:0]     stepUnit,
  output logic [NUM_DRIVES-1:0] driveBusy,
  output logic                  intPending,
  output logic [7:0]            st0Out,
  output logic [CYL_W-1:0]      pcnOut
);

  localparam int CNT_W = $clog2(RECAL_LIMIT + 1);
  localparam int GAP_W = RATE_W + 1;
  localparam logic [GAP_W-1:0] GAP_FULL = GAP_W'(1 << RATE_W);

  logic [UNIT_W-1:0]   curUnit;
  logic                curHead;
  logic                curRecal;
  logic [CYL_W-1:0]    target;
  logic [CNT_W-1:0]    stepCnt;
  logic [GAP_W-1:0]    gapTimer;
  logic [RATE_W-1:0]   rateQ;
  logic [7:0]          st0Reg;
  logic [CYL_W-1:0]    pcnReg;
  logic [NUM_DRIVES-1:0][CYL_W-1:0] pcnAll;
  logic [CYL_W-1:0]    curPcn;
  logic [GAP_W-1:0]    gapLen;
  logic                goUp;
  logic                finishAny;

  assign curPcn    = pcnAll[curUnit];
  assign gapLen    = GAP_FULL - {1'b0, rateQ};
  assign goUp      = ~curRecal & (target > curPcn);
  assign finishAny = ctl.finishOk | ctl.finishFail;

  assign flags.isRecal   = curRecal;
  assign flags.atTarget  = (curPcn == target);
  assign flags.trackZero = trackZero[curUnit];
  assign flags.limitHit  = (stepCnt == CNT_W'(RECAL_LIMIT));
  assign flags.gapDone   = (gapTimer == gapLen - GAP_W'(1));

  // one cylinder register and busy bit per drive
  for (genvar g = 0; g < NUM_DRIVES; g++) begin : g_drive
    logic [CYL_W-1:0] pcnQ;
    logic             busyQ;
    logic             selHit;
    assign selHit = (curUnit == UNIT_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pcnQ <= '0;
      end else if (ctl.stepNow && selHit && !curRecal) begin
        pcnQ <= goUp ? pcnQ + CYL_W'(1) : pcnQ - CYL_W'(1);
      end else if (ctl.finishOk && selHit && curRecal) begin
        pcnQ <= '0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    busyQ <= 1'b0;
      else if (ctl.latchReq && reqUnit == UNIT_W'(g)) busyQ <= 1'b1;
      else if (finishAny)                            busyQ <= 1'b0;
    end

    assign pcnAll[g]    = pcnQ;
    assign driveBusy[g] = busyQ;
  end

  // latched request and step counting
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      curUnit  <= '0;
      curHead  <= 1'b0;
      curRecal <= 1'b0;
      target   <= '0;
      stepCnt  <= '0;
    end else if (ctl.latchReq) begin
      curUnit  <= reqUnit;
      curHead  <= reqHead;
      curRecal <= reqRecal;
      target   <= reqCyl;
      stepCnt  <= '0;
    end else if (ctl.stepNow) begin
      stepCnt  <= stepCnt + CNT_W'(1);
    end
  end

  // pulse shaping and gap timer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stepOut  <= 1'b0;
      dirOut   <= 1'b0;
      gapTimer <= '0;
    end else begin
      if (ctl.stepNow) begin
        stepOut <= 1'b1;
        dirOut  <= goUp;
      end else if (ctl.endHigh) begin
        stepOut <= 1'b0;
      end
      if (ctl.endHigh)      gapTimer <= '0;
      else if (ctl.tickLow) gapTimer <= gapTimer + GAP_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rateQ <= '0;
    else if (specWe) rateQ <= specRate;
  end

  // completion status and sense path
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      intPending <= 1'b0;
      st0Reg     <= '0;
      pcnReg     <= '0;
    end else if (finishAny) begin
      intPending <= 1'b1;
      st0Reg     <= {1'b0, ctl.finishFail, 1'b1, ctl.finishFail,
                     1'b0, curHead, 2'(curUnit)};
      pcnReg     <= (ctl.finishOk && curRecal) ? '0 : curPcn;
    end else if (senseRd) begin
      intPending <= 1'b0;
    end
  end

  assign stepUnit = curUnit;
  assign st0Out   = intPending ? st0Reg : ST0_IDLE;
  assign pcnOut   = pcnReg;

endmodule

// File: rtl/head_step_ctrl.sv
module head_step_ctrl
  import head_step_pkg::*;
#(
  parameter int NUM_DRIVES  = 4,
  parameter int CYL_W       = 8,
  parameter int RATE_W      = 4,
  parameter int RECAL_LIMIT = 77,
  localparam int UNIT_W     = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  msTick,
  input  logic                  specWe,
  input  logic [RATE_W-1:0]     specRate,
  input  logic                  reqValid,
  input  logic                  reqRecal,
  input  logic [UNIT_W-1:0]     reqUnit,
  input  logic                  reqHead,
  input  logic [CYL_W-1:0]      reqCyl,
  output logic                  reqReady,
  input  logic [NUM_DRIVES-1:0] trackZero,
  input  logic                  senseRd,
  output logic                  stepOut,
  output logic                  dirOut,
  output logic [UNIT_W-1:0]     stepUnit,
  output logic [NUM_DRIVES-1:0] driveBusy,
  output logic                  intPending,
  output logic [7:0]            st0Out,
  output logic [CYL_W-1:0]      pcnOut
);

  ctrlStrobe_t ctl;
  dpFlags_t    flags;

  head_step_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .msTick   (msTick),
    .reqValid (reqValid),
    .flags    (flags),
    .reqReady (reqReady),
    .ctl      (ctl)
  );

  head_step_dp #(
    .NUM_DRIVES  (NUM_DRIVES),
    .CYL_W       (CYL_W),
    .RATE_W      (RATE_W),
    .RECAL_LIMIT (RECAL_LIMIT)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl        (ctl),
    .specWe     (specWe),
    .specRate   (specRate),
    .reqRecal   (reqRecal),
    .reqUnit    (reqUnit),
    .reqHead    (reqHead),
    .reqCyl     (reqCyl),
    .senseRd    (senseRd),
    .trackZero  (trackZero),
    .flags      (flags),
    .stepOut    (stepOut),
    .dirOut     (dirOut),
    .stepUnit   (stepUnit),
    .driveBusy  (driveBusy),
    .intPending (intPending),
    .st0Out     (st0Out),
    .pcnOut     (pcnOut)
  );

endmodule

// File: rtl/head_step_chk.sv
module head_step_chk #(
  parameter int NUM_DRIVES = 4,
  parameter int UNIT_W     = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  msTick,
  input logic                  senseRd,
  input logic                  reqReady,
  input logic                  stepOut,
  input logic                  dirOut,
  input logic [UNIT_W-1:0]     stepUnit,
  input logic [NUM_DRIVES-1:0] driveBusy,
  input logic                  intPending,
  input logic [7:0]            st0Out
);

  assert_ready_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reqReady |-> (driveBusy == '0));

  assert_dir_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (stepOut && $past(stepOut)) |-> $stable(dirOut));

  assert_step_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !msTick |=> $stable(stepOut));

  assert_busy_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(driveBusy));

  assert_step_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stepOut |-> driveBusy[stepUnit]);

  assert_int_on_finish_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(intPending) |-> ($past(driveBusy) != '0 && driveBusy == '0));

  assert_sense_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (intPending && senseRd && driveBusy == '0) |=> !intPending);

  assert_idle_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !intPending |-> (st0Out == 8'h80));

endmodule

bind head_step_ctrl head_step_chk #(
  .NUM_DRIVES (NUM_DRIVES),
  .UNIT_W     (UNIT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .msTick     (msTick),
  .senseRd    (senseRd),
  .reqReady   (reqReady),
  .stepOut    (stepOut),
  .dirOut     (dirOut),
  .stepUnit   (stepUnit),
  .driveBusy  (driveBusy),
  .intPending (intPending),
  .st0Out     (st0Out)
);

// File: tb/head_step_ctrl_tb.sv
module head_step_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       msTick = 1'b0;
  logic       specWe = 1'b0;
  logic [3:0] specRate = '0;
  logic       reqValid = 1'b0;
  logic       reqRecal = 1'b0;
  logic [1:0] reqUnit = '0;
  logic       reqHead = 1'b0;
  logic [7:0] reqCyl = '0;
  logic       reqReady;
  logic [3:0] trackZero;
  logic       senseRd = 1'b0;
  logic       stepOut, dirOut;
  logic [1:0] stepUnit;
  logic [3:0] driveBusy;
  logic       intPending;
  logic [7:0] st0Out;
  logic [7:0] pcnOut;

  head_step_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .msTick(msTick), .specWe(specWe),
    .specRate(specRate), .reqValid(reqValid), .reqRecal(reqRecal),
    .reqUnit(reqUnit), .reqHead(reqHead), .reqCyl(reqCyl),
    .reqReady(reqReady), .trackZero(trackZero), .senseRd(senseRd),
    .stepOut(stepOut), .dirOut(dirOut), .stepUnit(stepUnit),
    .driveBusy(driveBusy), .intPending(intPending), .st0Out(st0Out),
    .pcnOut(pcnOut)
  );

  always #5 clk = ~clk;

  typedef struct {
    logic [7:0] st0;
    logic [7:0] pcn;
    string      tag;
  } expItem_t;

  expItem_t expQ[$];
  int  nChecks = 0;
  int  nFails  = 0;
  int  tickIdx = 0;
  int  pulseCount = 0;
  int  dirBad = 0;
  int  lastRise = 0;
  int  lastSpacing = 0;
  int  lastWidth = 0;
  int  compCount = 0;
  bit  expDirVar = 1'b0;
  bit  prevStep = 1'b0;
  int  physPos[4] = '{0, 0, 0, 0};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  // physical drive model: drive 2 never reports track zero
  always_comb begin
    for (int d = 0; d < 4; d++) trackZero[d] = (physPos[d] == 0) && (d != 2);
  end

  // millisecond tick: one clock in five
  initial begin
    int div = 0;
    forever begin
      @(posedge clk);
      #2;
      if (div == 4) begin
        msTick = 1'b1;
        tickIdx++;
        div = 0;
      end else begin
        msTick = 1'b0;
        div++;
      end
    end
  end

  // monitor: pulse tracking and scoreboard of completions
  always @(negedge clk) begin
    if (rst_n) begin
      if (stepOut && !prevStep) begin
        pulseCount++;
        if (dirOut != expDirVar) dirBad++;
        lastSpacing = tickIdx - lastRise;
        lastRise = tickIdx;
        if (dirOut) physPos[stepUnit] = physPos[stepUnit] + 1;
        else if (physPos[stepUnit] > 0) physPos[stepUnit] = physPos[stepUnit] - 1;
      end
      if (!stepOut && prevStep) lastWidth = tickIdx - lastRise;
      prevStep = stepOut;

      if (intPending && !senseRd) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R9", 1, 0);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          chk(st0Out == e.st0, e.tag, int'(st0Out), int'(e.st0));
          chk(pcnOut == e.pcn, e.tag, int'(pcnOut), int'(e.pcn));
        end
        senseRd = 1'b1;
        compCount++;
      end else begin
        senseRd = 1'b0;
      end
    end
  end

  task automatic setRate(input logic [3:0] r);
    @(negedge clk);
    specRate = r;
    specWe = 1'b1;
    @(negedge clk);
    specWe = 1'b0;
  endtask

  task automatic runMove(input bit recal, input int unit, input bit head, input int cyl,
                         input int expPulses, input bit expDir, input logic [7:0] expSt0,
                         input int expPcn, input int maxLat, input string tag);
    int lat;
    int prevComp;
    expQ.push_back('{expSt0, 8'(expPcn), tag});
    expDirVar = expDir;
    dirBad = 0;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    pulseCount = 0;
    prevComp = compCount;
    reqRecal = recal;
    reqUnit = 2'(unit);
    reqHead = head;
    reqCyl = 8'(cyl);
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    lat = 0;
    while (!intPending && lat < 20000) begin
      @(negedge clk);
      lat++;
    end
    wait (compCount == prevComp + 1);
    chk(pulseCount == expPulses, tag, pulseCount, expPulses);
    if (expPulses > 0) chk(dirBad == 0, tag, dirBad, 0);
    if (maxLat > 0) chk(lat <= maxLat, "R5", lat, maxLat);
    @(negedge clk);
    chk(!intPending && st0Out == 8'h80, "R9", int'(st0Out), 8'h80);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(reqReady == 1'b1, "R1", int'(reqReady), 1);
    chk(stepOut == 1'b0, "R1", int'(stepOut), 0);
    chk(driveBusy == 4'b0, "R1", int'(driveBusy), 0);
    chk(intPending == 1'b0, "R1", int'(intPending), 0);
    chk(st0Out == 8'h80, "R1", int'(st0Out), 8'h80);
    chk(pcnOut == 8'h00, "R1", int'(pcnOut), 0);

    setRate(4'd15);
    // R3 outward and inward seeks
    runMove(1'b0, 0, 1'b0, 5, 5, 1'b1, 8'h20, 5, 0, "R3");
    runMove(1'b0, 0, 1'b1, 2, 3, 1'b0, 8'h24, 2, 0, "R3");
    // R5 zero-length seek
    runMove(1'b0, 1, 1'b1, 0, 0, 1'b0, 8'h25, 0, 1, "R5");
    runMove(1'b0, 1, 1'b0, 7, 7, 1'b1, 8'h21, 7, 0, "R3");
    // R10 drive 0 kept its cylinder
    runMove(1'b0, 0, 1'b0, 2, 0, 1'b0, 8'h20, 2, 0, "R10");
    // R6 recalibrate finds track zero
    runMove(1'b1, 0, 1'b0, 0, 2, 1'b0, 8'h20, 0, 0, "R6");
    runMove(1'b0, 2, 1'b0, 3, 3, 1'b1, 8'h22, 3, 0, "R3");
    // R7 recalibrate hits the step limit
    runMove(1'b1, 2, 1'b1, 0, 77, 1'b0, 8'h76, 3, 0, "R7");

    // R2 request during a move is ignored; R8 busy bit
    fork
      runMove(1'b0, 3, 1'b0, 4, 4, 1'b1, 8'h23, 4, 0, "R2");
      begin
        wait (driveBusy[3] === 1'b1);
        @(negedge clk);
        chk(reqReady == 1'b0, "R2", int'(reqReady), 0);
        chk(driveBusy == 4'b1000, "R8", int'(driveBusy), 8);
        reqRecal = 1'b0;
        reqUnit = 2'd3;
        reqCyl = 8'd9;
        reqValid = 1'b1;
        @(negedge clk);
        reqValid = 1'b0;
      end
    join

    // R4 pulse width and spacing
    setRate(4'd13);
    runMove(1'b0, 1, 1'b0, 9, 2, 1'b1, 8'h21, 9, 0, "R4");
    chk(lastWidth == 1, "R4", lastWidth, 1);
    chk(lastSpacing == 4, "R4", lastSpacing, 4);
    setRate(4'd0);
    runMove(1'b0, 1, 1'b0, 11, 2, 1'b1, 8'h21, 11, 0, "R4");
    chk(lastWidth == 1, "R4", lastWidth, 1);
    chk(lastSpacing == 17, "R4", lastSpacing, 17);

    chk(expQ.size() == 0, "R9", expQ.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule